// File: doc/BRIEF.md
# Two-Level Reservation Output Arbiter

This block arbitrates one output port of a five-input router crossbar. Each input can ask for the port in one of two ways. A confirmed request means the input has finished computing its route. A tentative request is made early, on behalf of an idle input whose predictor names this port, so that a flit arriving later can cross without waiting for allocation. Confirmed requests always beat tentative ones. Inside each class, a round-robin pointer spreads the wins fairly.

The arbiter keeps a grant for the whole of a packet and drops it when the tail flit goes through. A tentative grant is used when its predicted flit arrives, or when the same input confirms this port. It is taken back in three cases: another input makes a confirmed request, the owner sends a kill after a misprediction, or the owner withdraws its prediction. The outputs are a registered one-hot grant and a flag that marks a grant as tentative.

Top module: `resv_out_arb`

## Requirements
- R1: When the port is free and both classes are requesting, the grant that appears on the next cycle goes to a confirmed requester, and `grant_tent` is 0.
- R2: When the port is free and only tentative requests are present, the next cycle shows a grant to one of those inputs, with `grant_tent` at 1.
- R3: Among confirmed requesters, the search starts at the confirmed pointer and moves upward, wrapping from input 4 to input 0. After each confirmed grant the pointer moves to the input just past the winner. The pointer resets to 0.
- R4: Tentative grants use their own round-robin pointer, which follows the same rules as the confirmed pointer and also resets to 0.
- R5: Take a tentative grant whose owner shows no flit, no kill and no confirmed request in a cycle. If another input asserts a confirmed request in that cycle, the port passes on the next cycle to the confirmed round-robin winner, with `grant_tent` at 0.
- R6: A tentative grant becomes a held grant, keeping the same input and clearing `grant_tent`, when the owner presents a flit without tail or asserts its own confirmed request. Once held, confirmed requests from other inputs do not move it.
- R7: A kill from the owner of a grant, whether tentative or held, leaves the port free (`grant` all zero) on the next cycle. A kill from any other input has no effect.
- R8: A held grant stays the same until the owner passes a flit with `flit_tail` set. The port is free on the next cycle, and a new arbitration can appear one cycle after that.
- R9: If the owner of a tentative grant drops its tentative request without sending a flit, confirming, or being revoked, the port is free on the next cycle.
- R10: `grant` never has more than one bit set.
- R11: During reset and after it, `grant` is all zero and `grant_tent` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conf_req | input | 5 | Confirmed request, one bit per input |
| tent_req | input | 5 | Tentative (predicted) request, one bit per input |
| flit_valid | input | 5 | Input is sending a flit through this port in this cycle |
| flit_tail | input | 5 | That flit is the last one of its packet |
| kill | input | 5 | Input reports a misprediction and gives up its reservation |
| grant | output | 5 | One-hot registered grant |
| grant_tent | output | 1 | The current grant is tentative |

## Verification
The hardest cases are the ones where two rules compete in the same cycle. One case: a tentative grant is pending, another input raises a confirmed request, and the owner may also send its first flit in that same cycle. The bench drives the revoke without the flit and expects the grant to move to the confirmed winner. It then drives the flit together with a foreign confirmed request and expects the grant to stay where it is, now as a held grant. A second case: a confirmed grant and a foreign kill arrive together, and the held grant must not change.

// File: rtl/resv_arb_pkg.sv
package resv_arb_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_TENT = 2'd1,
        ST_HELD = 2'd2
    } hold_e;
endpackage

// File: rtl/resv_rr_pick.sv
// Round-robin pick: first set request at or after ptr, wrapping.
module resv_rr_pick #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!found && req[IW'(j)]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/resv_onehot.sv
module resv_onehot #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  vec
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign vec[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/resv_out_arb.sv
module resv_out_arb
    import resv_arb_pkg::*;
#(
    parameter int NUM_IN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] conf_req,
    input  logic [NUM_IN-1:0] tent_req,
    input  logic [NUM_IN-1:0] flit_valid,
    input  logic [NUM_IN-1:0] flit_tail,
    input  logic [NUM_IN-1:0] kill,
    output logic [NUM_IN-1:0] grant,
    output logic              grant_tent
);
    localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int NLVL = 2;  // level 0 confirmed, level 1 tentative

    typedef struct packed {
        hold_e         st;
        logic [IW-1:0] owner;
        logic [IW-1:0] cptr;
        logic [IW-1:0] tptr;
    } arb_s;

    arb_s cur_q, nxt_d;

    logic [NUM_IN-1:0] lvl_req [NLVL];
    logic [IW-1:0]     lvl_ptr [NLVL];
    logic              lvl_found [NLVL];
    logic [IW-1:0]     lvl_idx [NLVL];

    assign lvl_req[0] = conf_req;
    assign lvl_req[1] = tent_req;
    assign lvl_ptr[0] = cur_q.cptr;
    assign lvl_ptr[1] = cur_q.tptr;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        resv_rr_pick #(.N(NUM_IN), .IW(IW)) u_pick (
            .req  (lvl_req[l]),
            .ptr  (lvl_ptr[l]),
            .found(lvl_found[l]),
            .idx  (lvl_idx[l])
        );
    end

    function automatic logic [IW-1:0] step_ptr(input logic [IW-1:0] w);
        return (w == IW'(NUM_IN - 1)) ? '0 : w + 1'b1;
    endfunction

    logic own_flit, own_tail, own_kill, own_conf, own_tent;
    assign own_flit = flit_valid[cur_q.owner];
    assign own_tail = flit_tail[cur_q.owner];
    assign own_kill = kill[cur_q.owner];
    assign own_conf = conf_req[cur_q.owner];
    assign own_tent = tent_req[cur_q.owner];

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_FREE: begin
                if (lvl_found[0]) begin
                    nxt_d.st    = ST_HELD;
                    nxt_d.owner = lvl_idx[0];
                    nxt_d.cptr  = step_ptr(lvl_idx[0]);
                end else if (lvl_found[1]) begin
                    nxt_d.st    = ST_TENT;
                    nxt_d.owner = lvl_idx[1];
                    nxt_d.tptr  = step_ptr(lvl_idx[1]);
                end
            end
            ST_TENT: begin
                if (own_kill) begin
                    nxt_d.st = ST_FREE;
                end else if (own_flit) begin
                    nxt_d.st = own_tail ? ST_FREE : ST_HELD;
                end else if (own_conf) begin
                    nxt_d.st = ST_HELD;
                end else if (lvl_found[0]) begin
                    nxt_d.st    = ST_HELD;
                    nxt_d.owner = lvl_idx[0];
                    nxt_d.cptr  = step_ptr(lvl_idx[0]);
                end else if (!own_tent) begin
                    nxt_d.st = ST_FREE;
                end
            end
            ST_HELD: begin
                if (own_kill || (own_flit && own_tail)) nxt_d.st = ST_FREE;
            end
            default: nxt_d.st = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_FREE, owner: '0, cptr: '0, tptr: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    resv_onehot #(.N(NUM_IN), .IW(IW)) u_dec (
        .en (cur_q.st != ST_FREE),
        .idx(cur_q.owner),
        .vec(grant)
    );
    assign grant_tent = (cur_q.st == ST_TENT);

    // Assertions on port behaviour
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_conf_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && conf_req != '0) |=> (grant != '0 && !grant_tent));

    p_kill_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & kill) != '0) |=> (grant == '0));

    p_tail_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !grant_tent && (grant & flit_valid & flit_tail) != '0)
        |=> (grant == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !grant_tent && (grant & (kill | flit_tail)) == '0)
        |=> $stable(grant));

    p_revoke_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_tent && (grant & (flit_valid | kill | conf_req)) == '0
         && (conf_req & ~grant) != '0)
        |=> (!grant_tent && grant != '0 && grant != $past(grant)));
endmodule

// File: tb/resv_out_arb_test.sv
module resv_out_arb_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] conf_req = '0, tent_req = '0, flit_valid = '0, flit_tail = '0, kill = '0;
    logic [4:0] grant;
    logic       grant_tent;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [4:0] g;
        logic       t;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    resv_out_arb #(.NUM_IN(5)) uut (
        .clk(clk), .rst_n(rst_n), .conf_req(conf_req), .tent_req(tent_req),
        .flit_valid(flit_valid), .flit_tail(flit_tail), .kill(kill),
        .grant(grant), .grant_tent(grant_tent)
    );

    task automatic step(input logic [4:0] c, input logic [4:0] t,
                        input logic [4:0] fv, input logic [4:0] ft,
                        input logic [4:0] k, input logic [4:0] eg,
                        input logic et, input string tag);
        exp_t e;
        @(negedge clk);
        conf_req = c; tent_req = t; flit_valid = fv; flit_tail = ft; kill = k;
        e.g = eg; e.t = et; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compares each result after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (grant !== e.g || grant_tent !== e.t) begin
                    fails++;
                    $display("FAIL %s: grant=%b tent=%b expected grant=%b tent=%b",
                             e.tag, grant, grant_tent, e.g, e.t);
                end
                checks++;
                if (!$onehot0(grant)) begin
                    fails++;
                    $display("FAIL R10: grant=%b expected at most one bit", grant);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (grant !== 5'b0 || grant_tent !== 1'b0) begin
            fails++;
            $display("FAIL R11: grant=%b tent=%b expected 00000 0", grant, grant_tent);
        end
        @(negedge clk);
        rst_n = 1'b1;
        //    conf     tent     fvalid   ftail    kill     grant   tent tag
        step(5'b00110, 5'b00001, 5'b0,    5'b0,    5'b0,    5'b00010, 0, "R1");
        step(5'b00110, 5'b0,    5'b00010, 5'b0,    5'b0,    5'b00010, 0, "R8");
        step(5'b0,    5'b0,    5'b00010, 5'b00010, 5'b0,    5'b00000, 0, "R8");
        step(5'b00110, 5'b0,    5'b0,    5'b0,    5'b0,    5'b00100, 0, "R3");
        step(5'b0,    5'b0,    5'b00100, 5'b00100, 5'b0,    5'b00000, 0, "R8");
        step(5'b00011, 5'b0,    5'b0,    5'b0,    5'b0,    5'b00001, 0, "R3");
        step(5'b0,    5'b0,    5'b0,    5'b0,    5'b00001, 5'b00000, 0, "R7");
        step(5'b0,    5'b10010, 5'b0,    5'b0,    5'b0,    5'b00010, 1, "R2");
        step(5'b01000, 5'b10010, 5'b0,    5'b0,    5'b0,    5'b01000, 0, "R5");
        step(5'b0,    5'b0,    5'b01000, 5'b01000, 5'b0,    5'b00000, 0, "R8");
        step(5'b0,    5'b10010, 5'b0,    5'b0,    5'b0,    5'b10000, 1, "R4");
        step(5'b00001, 5'b10010, 5'b10000, 5'b0,    5'b0,    5'b10000, 0, "R6");
        step(5'b00001, 5'b0,    5'b0,    5'b0,    5'b0,    5'b10000, 0, "R6");
        step(5'b00001, 5'b0,    5'b0,    5'b0,    5'b00001, 5'b10000, 0, "R7");
        step(5'b0,    5'b0,    5'b10000, 5'b10000, 5'b0,    5'b00000, 0, "R8");
        step(5'b0,    5'b00010, 5'b0,    5'b0,    5'b0,    5'b00010, 1, "R4");
        step(5'b0,    5'b0,    5'b0,    5'b0,    5'b0,    5'b00000, 0, "R9");
        step(5'b0,    5'b00100, 5'b0,    5'b0,    5'b0,    5'b00100, 1, "R4");
        step(5'b00100, 5'b0,    5'b0,    5'b0,    5'b0,    5'b00100, 0, "R6");
        step(5'b0,    5'b0,    5'b0,    5'b0,    5'b00100, 5'b00000, 0, "R7");
        step(5'b0,    5'b00010, 5'b0,    5'b0,    5'b0,    5'b00010, 1, "R4");
        step(5'b0,    5'b00010, 5'b0,    5'b0,    5'b00010, 5'b00000, 0, "R7");
        step(5'b10001, 5'b0,    5'b0,    5'b0,    5'b0,    5'b10000, 0, "R3");
        step(5'b0,    5'b0,    5'b10000, 5'b10000, 5'b0,    5'b00000, 0, "R8");
        step(5'b0,    5'b0,    5'b0,    5'b0,    5'b0,    5'b00000, 0, "R11");
        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule